// File: doc/BRIEF.md
# Accumulator ALU with Half-Carry Flags

This block is the arithmetic and logic unit of a small accumulator CPU. Each cycle it takes an operation code, the accumulator byte, a second operand byte, a bit index and the current flag byte. From these it forms a result byte, a decrement destination byte and one write-enable for each of the two. It also forms the next flag byte and the number of clock cycles that the instruction costs. All of these paths are combinational.

There are four flags: zero, subtract, half-carry and carry. The half-carry flag reports a carry or borrow between bit 3 and bit 4. For every operation, each flag is either computed, forced to one, forced to zero or passed through unchanged.

A registered stage follows the combinational paths. It loads the next flag byte on a rising clock edge when the enable input is high and holds its value otherwise. The surrounding core decodes instructions, owns the register file and feeds the registered flags back as the next `flg_in`.

Top module: `acc_alu`

## Requirements
- R1: Select code 0 (OR) sets the result to `acc_in | opr_in` and raises `acc_we`. Zero is set only when the result is 0x00. Subtract, half-carry and carry are cleared.
- R2: Select code 1 (add-with-carry) sets the result to (`acc_in` + `opr_in` + carry-in) mod 256. Carry-in is `flg_in` bit 4. Carry is set when the unshifted sum exceeds 0xFF. Half-carry is set when the two low nibbles plus carry-in exceed 0xF. Zero reflects the 8-bit result, subtract is cleared and `acc_we` is raised.
- R3: Select code 2 (compare) forms `acc_in - opr_in` without writing it. Zero is set when the difference is zero. Carry is set when `acc_in < opr_in` (unsigned). Half-carry is set when the low nibble of the difference is greater than the low nibble of `acc_in`. Subtract is set.
- R4: Select code 3 (decrement) puts (`opr_in` - 1) mod 256 on `dst_out` and raises `dst_we`. Zero is set when that value is zero and half-carry when its low nibble is 0xF. Subtract is set and carry is passed through. `dst_we` is never high for any other code.
- R5: Select code 4 (complement carry) inverts carry and clears subtract and half-carry. Zero is passed through.
- R6: Select code 5 (bit test) tests bit `bit_sel` of `opr_in`. Zero is set when that bit is 0, subtract is cleared, half-carry is set and carry is passed through.
- R7: `cost` is 4 for codes 0 to 4, 8 for code 5, and 0 for the unused codes.
- R8: The flag byte places zero, subtract, half-carry and carry in bits 7, 6, 5 and 4. Bits 3 to 0 of `flg_nxt` and `flg_q` are always 0.
- R9: `acc_we` is high only for codes 0 and 1. Whenever `acc_we` is low, `res_out` equals `acc_in`.
- R10: For the unused codes 6 and 7, `flg_nxt[7:4]` equals `flg_in[7:4]`, `res_out` equals `acc_in`, `dst_out` equals `opr_in`, and both write-enables are low.
- R11: On reset `flg_q` reads 0x00. When `en` is high at a rising edge, `flg_q` takes that cycle's `flg_nxt`. When `en` is low, `flg_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Flag capture enable |
| op_sel | input | 3 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opr_in | input | 8 | Second operand |
| bit_sel | input | 3 | Bit index for bit test |
| flg_in | input | 8 | Current flag byte (Z,N,H,C in bits 7..4) |
| res_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write-enable |
| dst_out | output | 8 | Decrement result |
| dst_we | output | 1 | Decrement destination write-enable |
| flg_nxt | output | 8 | Combinational next flag byte |
| flg_q | output | 8 | Registered flag byte |
| cost | output | 4 | Cycle cost of the operation |

## Verification
The checker assumes that `op_sel`, `bit_sel` and the operands are stable and known around each rising edge. It accepts any value in `flg_in[3:0]`, because the outputs must ignore those bits. The bench therefore drives every input on the falling edge or between edges. It sets `flg_in` low bits to nonzero values to confirm that they are masked. In the clocked phase, `flg_in` is fed from both random values and the registered flags, so the capture checks see realistic feedback.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [2:0] {
      OP_OR  = 3'd0,
      OP_ADC = 3'd1,
      OP_CP  = 3'd2,
      OP_DEC = 3'd3,
      OP_CCF = 3'd4,
      OP_BIT = 3'd5
   } alu_op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

   localparam int FLAG_BYTE_W = 8;

   function automatic flags_t unpack_flags(input logic [FLAG_BYTE_W-1:0] b);
      flags_t f;
      f.z = b[7];
      f.n = b[6];
      f.h = b[5];
      f.c = b[4];
      return f;
   endfunction

   function automatic logic [FLAG_BYTE_W-1:0] pack_flags(input flags_t f);
      return {f.z, f.n, f.h, f.c, 4'b0000};
   endfunction
endpackage

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opr_in,
   input  logic [IDX_W-1:0]  bit_sel,
   input  flags_t            f_in,
   output logic [DATA_W-1:0] res,
   output logic              acc_we,
   output logic [DATA_W-1:0] dst,
   output logic              dst_we,
   output flags_t            f_out
);
   localparam int NIB = 4;

   logic [DATA_W:0]   add_w;
   logic [NIB:0]      add_nib;
   logic [DATA_W:0]   sub_w;
   logic [NIB:0]      sub_nib;
   logic [DATA_W-1:0] dec_v;
   logic [DATA_W-1:0] or_v;

   always_comb begin
      add_w   = {1'b0, acc_in} + {1'b0, opr_in} + {{DATA_W{1'b0}}, f_in.c};
      add_nib = {1'b0, acc_in[NIB-1:0]} + {1'b0, opr_in[NIB-1:0]}
                + {{NIB{1'b0}}, f_in.c};
      sub_w   = {1'b0, acc_in} - {1'b0, opr_in};
      sub_nib = {1'b0, acc_in[NIB-1:0]} - {1'b0, opr_in[NIB-1:0]};
      dec_v   = opr_in - {{(DATA_W-1){1'b0}}, 1'b1};
      or_v    = acc_in | opr_in;
   end

   always_comb begin
      res    = acc_in;
      dst    = opr_in;
      acc_we = 1'b0;
      dst_we = 1'b0;
      f_out  = f_in;
      case (op_sel)
         OP_OR: begin
            res    = or_v;
            acc_we = 1'b1;
            f_out  = '{z: (or_v == '0), n: 1'b0, h: 1'b0, c: 1'b0};
         end
         OP_ADC: begin
            res    = add_w[DATA_W-1:0];
            acc_we = 1'b1;
            f_out  = '{z: (add_w[DATA_W-1:0] == '0), n: 1'b0,
                       h: add_nib[NIB], c: add_w[DATA_W]};
         end
         OP_CP: begin
            f_out  = '{z: (sub_w[DATA_W-1:0] == '0), n: 1'b1,
                       h: sub_nib[NIB], c: sub_w[DATA_W]};
         end
         OP_DEC: begin
            dst    = dec_v;
            dst_we = 1'b1;
            f_out  = '{z: (dec_v == '0), n: 1'b1,
                       h: (dec_v[NIB-1:0] == {NIB{1'b1}}), c: f_in.c};
         end
         OP_CCF: begin
            f_out  = '{z: f_in.z, n: 1'b0, h: 1'b0, c: ~f_in.c};
         end
         OP_BIT: begin
            f_out  = '{z: ~opr_in[bit_sel], n: 1'b0, h: 1'b1, c: f_in.c};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_cost.sv
module acc_alu_cost
   import acc_alu_pkg::*;
#(
   parameter int COST_W     = 4,
   parameter int COST_SHORT = 4,
   parameter int COST_LONG  = 8
) (
   input  logic [2:0]        op_sel,
   output logic [COST_W-1:0] cost
);
   always_comb begin
      case (op_sel)
         OP_OR, OP_ADC, OP_CP, OP_DEC, OP_CCF: cost = COST_W'(COST_SHORT);
         OP_BIT:                               cost = COST_W'(COST_LONG);
         default:                              cost = '0;
      endcase
   end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg #(
   parameter int  W         = 8,
   parameter bit  REG_FLAGS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG_FLAGS) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (en) q <= d;
         end
      end else begin : g_pass
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int COST_W     = 4,
   parameter int COST_SHORT = 4,
   parameter int COST_LONG  = 8,
   parameter bit REG_FLAGS  = 1'b1,
   localparam int IDX_W     = $clog2(DATA_W)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [2:0]             op_sel,
   input  logic [DATA_W-1:0]      acc_in,
   input  logic [DATA_W-1:0]      opr_in,
   input  logic [IDX_W-1:0]       bit_sel,
   input  logic [FLAG_BYTE_W-1:0] flg_in,
   output logic [DATA_W-1:0]      res_out,
   output logic                   acc_we,
   output logic [DATA_W-1:0]      dst_out,
   output logic                   dst_we,
   output logic [FLAG_BYTE_W-1:0] flg_nxt,
   output logic [FLAG_BYTE_W-1:0] flg_q,
   output logic [COST_W-1:0]      cost
);
   generate
      if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
         $error("acc_alu: DATA_W must be a multiple of 4 and at least 8");
      end
      if (COST_LONG >= (1 << COST_W) || COST_SHORT >= (1 << COST_W)) begin : g_bad_cost
         $error("acc_alu: COST_W too narrow for cycle costs");
      end
   endgenerate

   flags_t f_in_s;
   flags_t f_out_s;

   assign f_in_s  = unpack_flags(flg_in);
   assign flg_nxt = pack_flags(f_out_s);

   acc_alu_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
      .op_sel (op_sel),
      .acc_in (acc_in),
      .opr_in (opr_in),
      .bit_sel(bit_sel),
      .f_in   (f_in_s),
      .res    (res_out),
      .acc_we (acc_we),
      .dst    (dst_out),
      .dst_we (dst_we),
      .f_out  (f_out_s)
   );

   acc_alu_cost #(.COST_W(COST_W), .COST_SHORT(COST_SHORT),
                  .COST_LONG(COST_LONG)) u_cost (
      .op_sel(op_sel),
      .cost  (cost)
   );

   acc_alu_flagreg #(.W(FLAG_BYTE_W), .REG_FLAGS(REG_FLAGS)) u_freg (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d    (flg_nxt),
      .q    (flg_q)
   );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int DATA_W = 8,
   parameter int COST_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [2:0]        op_sel,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] opr_in,
   input logic [7:0]        flg_in,
   input logic [DATA_W-1:0] res_out,
   input logic              acc_we,
   input logic              dst_we,
   input logic [7:0]        flg_nxt,
   input logic [7:0]        flg_q,
   input logic [COST_W-1:0] cost
);
   AST_OR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd0) |-> (flg_nxt[6:4] == 3'b000 && res_out == (acc_in | opr_in))); // R1
   AST_DST_WE_DEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> (op_sel == 3'd3)); // R4
   AST_CCF_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd4) |-> (flg_nxt[4] != flg_in[4] && flg_nxt[7] == flg_in[7]
                            && flg_nxt[6:5] == 2'b00)); // R5
   AST_BIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd5) |-> (flg_nxt[6:4] == {2'b01, flg_in[4]} && !acc_we && !dst_we)); // R6
   AST_BIT_COST: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd5) |-> (cost == COST_W'(8))); // R7
   AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_nxt[3:0] == 4'h0 && flg_q[3:0] == 4'h0)); // R8
   AST_ACC_WE_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we |-> (op_sel == 3'd0 || op_sel == 3'd1)); // R9
   AST_NO_WRITE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_we |-> (res_out == acc_in)); // R9
   AST_UNUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > 3'd5) |-> (flg_nxt[7:4] == flg_in[7:4] && !acc_we && !dst_we
                           && cost == '0)); // R10
   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (flg_q == $past(flg_nxt))); // R11
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(flg_q)); // R11
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .COST_W(COST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel), .acc_in(acc_in),
   .opr_in(opr_in), .flg_in(flg_in), .res_out(res_out), .acc_we(acc_we),
   .dst_we(dst_we), .flg_nxt(flg_nxt), .flg_q(flg_q), .cost(cost)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] op_sel = 3'd7;
   logic [7:0] acc_in = '0, opr_in = '0;
   logic [2:0] bit_sel = '0;
   logic [7:0] flg_in = '0;
   logic [7:0] res_out, dst_out, flg_nxt, flg_q;
   logic       acc_we, dst_we;
   logic [3:0] cost;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   acc_alu u_acc_alu (
      .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel), .acc_in(acc_in),
      .opr_in(opr_in), .bit_sel(bit_sel), .flg_in(flg_in), .res_out(res_out),
      .acc_we(acc_we), .dst_out(dst_out), .dst_we(dst_we), .flg_nxt(flg_nxt),
      .flg_q(flg_q), .cost(cost)
   );

   // expected outputs, filled by the reference model
   int e_res, e_dst, e_flags, e_cost;
   bit e_awe, e_dwe;

   function automatic string req_of(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic model(input int op, input int a, input int b, input int idx, input int f);
      int z, n, h, c, r;
      z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
      e_res = a; e_dst = b; e_awe = 0; e_dwe = 0; e_cost = 4;
      case (op)
         0: begin
            r = a | b; e_res = r & 255; e_awe = 1;
            z = ((r & 255) == 0); n = 0; h = 0; c = 0;
         end
         1: begin
            r = a + b + c;
            h = ((a % 16) + (b % 16) + c > 15);
            c = (r > 255); e_res = r & 255; e_awe = 1;
            z = ((r & 255) == 0); n = 0;
         end
         2: begin
            r = a - b;
            z = ((r & 255) == 0); c = (a < b);
            h = ((r & 15) > (a & 15)); n = 1;
         end
         3: begin
            r = (b + 255) % 256; e_dst = r; e_dwe = 1;
            z = (r == 0); h = ((r & 15) == 15); n = 1;
         end
         4: begin c = 1 - c; n = 0; h = 0; end
         5: begin z = (((b >> idx) & 1) == 0); n = 0; h = 1; e_cost = 8; end
         default: e_cost = 0;
      endcase
      e_flags = (z << 7) | (n << 6) | (h << 5) | (c << 4);
   endtask

   task automatic check_comb(input int op, input int a, input int b, input int idx, input int f);
      op_sel = op[2:0]; acc_in = a[7:0]; opr_in = b[7:0];
      bit_sel = idx[2:0]; flg_in = f[7:0];
      #1;
      model(op, a, b, idx, f);
      tests++;
      if (int'(res_out) != e_res || acc_we != e_awe || int'(dst_out) != e_dst ||
          dst_we != e_dwe || int'(flg_nxt) != e_flags || int'(cost) != e_cost) begin
         fails++;
         if (fails < 20)
            $display("FAIL %s/R7/R8/R9 op=%0d a=%02h b=%02h i=%0d f=%02h: got res=%02h awe=%0b dst=%02h dwe=%0b flg=%02h cost=%0d exp res=%02h awe=%0b dst=%02h dwe=%0b flg=%02h cost=%0d",
                     req_of(op), op, a, b, idx, f, res_out, acc_we, dst_out, dst_we,
                     flg_nxt, cost, e_res, e_awe, e_dst, e_dwe, e_flags, e_cost);
      end
   endtask

   task automatic check_q(input int exp, input string tag);
      tests++;
      if (int'(flg_q) != exp) begin
         fails++;
         $display("FAIL %s flg_q got %02h exp %02h", tag, flg_q, exp);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      int held, exp_q, nxt_q;
      bit pend;
      repeat (3) @(negedge clk);
      check_q(0, "R11 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_q(0, "R11 reset-hold");

      // exhaustive combinational sweeps, en low throughout
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++) begin
            check_comb(0, a, b, 0, (a & 1) ? 8'hF5 : 8'h00);   // R1
            check_comb(2, a, b, 0, 8'h0A);                      // R3
            for (int c = 0; c < 2; c++)
               check_comb(1, a, b, 0, c ? 8'h1F : 8'hE0);       // R2 with both carry-ins
         end
      for (int b = 0; b < 256; b++) begin
         check_comb(3, 8'h3C, b, 0, 8'h10);                     // R4 carry 1 preserved
         check_comb(3, 8'h3C, b, 0, 8'hE3);                     // R4 carry 0 preserved
         for (int i = 0; i < 8; i++) begin
            check_comb(5, b, b ^ 8'h5A, i, 8'h0F);              // R6
            check_comb(5, 8'h00, b, i, 8'hD7);                  // R6 carry kept
         end
      end
      for (int f = 0; f < 256; f++) begin
         check_comb(4, 8'h77, 8'h11, 0, f);                     // R5
         check_comb(6, f, 255 - f, 3, f);                       // R10
         check_comb(7, 255 - f, f, 5, f);                       // R10
      end
      check_q(0, "R11 hold while en low");

      // clocked phase with feedback; compare every clock
      exp_q = 0; pend = 0; nxt_q = 0;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if (pend) exp_q = nxt_q;
         check_q(exp_q, "R11 capture/hold");
         held = (k % 3 == 0) ? int'(flg_q) : int'($urandom_range(0, 255));
         op_sel = 3'($urandom_range(0, 7));
         acc_in = 8'($urandom_range(0, 255));
         opr_in = 8'($urandom_range(0, 255));
         bit_sel = 3'($urandom_range(0, 7));
         flg_in = held[7:0];
         en = ($urandom_range(0, 3) != 0);
         #1;
         model(int'(op_sel), int'(acc_in), int'(opr_in), int'(bit_sel), int'(flg_in));
         tests++;
         if (int'(flg_nxt) != e_flags || int'(cost) != e_cost) begin
            fails++;
            $display("FAIL %s/R7 clocked op=%0d flg got %02h exp %02h cost got %0d exp %0d",
                     req_of(int'(op_sel)), op_sel, flg_nxt, e_flags, cost, e_cost);
         end
         pend = en; nxt_q = e_flags;
      end
      @(negedge clk);
      if (pend) exp_q = nxt_q;
      check_q(exp_q, "R11 final");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule